// File: doc/BRIEF.md
# Write-Protection Command Gate

This block sits ahead of the sector write path of a byte-programmed nonvolatile array. It watches every byte load and forwards ordinary data bytes to the sector buffer. Some byte loads form a short command key: a fixed series of address/data pairs. The block keeps those bytes out of the buffer and uses them to switch a persistent protection mode on or off.

While protection is on, a load period may commit only if it opens with the three-byte unlock key. A period that carries data without the key still starts the busy timer, so status polling behaves as usual, but no data is committed. The block measures the load period itself. A period closes once no byte has arrived for a programmable number of cycles. At that point the block issues exactly one verdict: commit, or timer only.

Command bytes obey the same window as data bytes. An unfinished key is dropped when the period closes. Protection is off after reset, which represents the delivered state. The protection bit is changed only by the two key sequences.

Top module: `wp_gate`

## Requirements
- R1: After reset, `protectOn`, `fwdValid`, `writePermit` and `timerOnly` are all 0.
- R2: A byte accepted as data appears on `fwdValid`/`fwdAddr`/`fwdData` in the cycle after the load strobe, with the same address and data.
- R3: A load period closes exactly WINDOW clock cycles after its last load strobe. A load that arrives within the window extends the period, and the verdict pulse appears WINDOW cycles after the last load.
- R4: The unlock key consists of three loads with no data byte before them in the period: address 0x5555 with data 0xAA, then 0x2AAA with 0x55, then 0x5555 with 0xA0. It sets `protectOn` to 1 whatever its previous value. Its bytes are not forwarded.
- R5: While `protectOn` is 1, a period that holds data bytes but no unlock key ends with a one-cycle `timerOnly` pulse and no `writePermit`.
- R6: While protected, a period that opens with the unlock key and then holds data ends with a one-cycle `writePermit` pulse. Protection stays on for the next period.
- R7: The disable key consists of six loads at the start of a period: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. It clears `protectOn` one cycle after its last byte. None of its bytes are forwarded. Data loaded after it in the same period ends with `writePermit`.
- R8: A load that does not match the next expected key byte returns the matcher to idle. That load is forwarded as data. The key bytes accepted before it are not forwarded.
- R9: Keys are only recognised before the first data byte of a period and before an unlock completes. Later key-like bytes are forwarded as data and do not change `protectOn`.
- R10: A period that holds only key bytes ends with neither `writePermit` nor `timerOnly`.
- R11: `writePermit` and `timerOnly` are never 1 in the same cycle, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; returns to the delivered, unprotected state |
| loadValid | input | 1 | One-cycle strobe per decoded byte load |
| loadAddr | input | ADDR_W | Address of the byte load |
| loadData | input | DATA_W | Data of the byte load |
| fwdValid | output | 1 | Registered strobe: byte goes to the sector buffer |
| fwdAddr | output | ADDR_W | Address of the forwarded byte |
| fwdData | output | DATA_W | Data of the forwarded byte |
| writePermit | output | 1 | One-cycle pulse at period close: commit the buffer |
| timerOnly | output | 1 | One-cycle pulse at period close: run busy timer, commit nothing |
| protectOn | output | 1 | Current persistent protection mode |

## Verification
The hardest case to reach is a key that diverges part-way through. The matcher has to fall back to idle, and the diverging byte has to count as data. That byte then determines the verdict of a protected period, even though the bytes before it were swallowed. The bench reaches this case by arming protection with the table-driven period. It then opens a new period with one correct key byte and follows it with a near-miss second byte. The stimulus also covers a key-only period, a disable key that runs through all six steps, and key bytes sent after data. These show that recognition stops once data has appeared.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

  localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
  localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;
  localparam logic [7:0]  KEY_OPEN    = 8'hAA;
  localparam logic [7:0]  KEY_CONFIRM = 8'h55;
  localparam logic [7:0]  KEY_ARM     = 8'hA0;
  localparam logic [7:0]  KEY_ESCAPE  = 8'h80;
  localparam logic [7:0]  KEY_RELEASE = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5
  } seqStep_t;

  typedef struct packed {
    logic keyOpen;     // open byte at the high key address
    logic keyConfirm;  // confirm byte at the low key address
    logic keyArm;      // arm byte at the high key address
    logic keyEscape;   // escape byte at the high key address
    logic keyRelease;  // release byte at the high key address
  } keyHit_t;

  typedef struct packed {
    logic fwdEn;     // forward the present load to the buffer
    logic cycleEnd;  // period closes with data present
    logic permit;    // verdict when cycleEnd is set
  } gateStrobe_t;

endpackage

// File: rtl/wp_gate_datapath.sv
module wp_gate_datapath
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  gateStrobe_t       strobe,
  output keyHit_t           hits,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              writePermit,
  output logic              timerOnly
);

  localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(KEY_ADDR_HI);
  localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(KEY_ADDR_LO);

  logic atHi, atLo;

  always_comb begin
    atHi = (loadAddr == ADDR_HI);
    atLo = (loadAddr == ADDR_LO);
    hits.keyOpen    = atHi && (loadData == DATA_W'(KEY_OPEN));
    hits.keyConfirm = atLo && (loadData == DATA_W'(KEY_CONFIRM));
    hits.keyArm     = atHi && (loadData == DATA_W'(KEY_ARM));
    hits.keyEscape  = atHi && (loadData == DATA_W'(KEY_ESCAPE));
    hits.keyRelease = atHi && (loadData == DATA_W'(KEY_RELEASE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid    <= 1'b0;
      fwdAddr     <= '0;
      fwdData     <= '0;
      writePermit <= 1'b0;
      timerOnly   <= 1'b0;
    end else begin
      fwdValid    <= strobe.fwdEn;
      writePermit <= strobe.cycleEnd && strobe.permit;
      timerOnly   <= strobe.cycleEnd && !strobe.permit;
      if (strobe.fwdEn) begin
        fwdAddr <= loadAddr;
        fwdData <= loadData;
      end
    end
  end

  // R11: one verdict per period, never both
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(writePermit && timerOnly));
  // R11: a verdict pulse lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (writePermit || timerOnly) |=> !(writePermit || timerOnly));

endmodule

// File: rtl/wp_gate_control.sv
module wp_gate_control
  import wp_gate_pkg::*;
#(
  parameter int WINDOW = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadValid,
  input  keyHit_t     hits,
  output gateStrobe_t strobe,
  output logic        protectOn
);

  localparam int CNT_W = $clog2(WINDOW + 1);

  seqStep_t   step, stepNext;
  logic       armed, armedNext;
  logic       protectQ, protectNext;
  logic       dataSeen, dataSeenNext;
  logic       periodOpen;
  logic [CNT_W-1:0] quietCnt;
  logic       windowDone, hunting, fwd;

  always_comb begin
    windowDone   = periodOpen && (quietCnt == CNT_W'(WINDOW - 1));
    hunting      = !dataSeen && !armed;
    stepNext     = step;
    armedNext    = armed;
    protectNext  = protectQ;
    dataSeenNext = dataSeen;
    fwd          = 1'b0;
    if (loadValid) begin
      if (hunting) begin
        unique case (step)
          ST_IDLE: if (hits.keyOpen) stepNext = ST_K1; else fwd = 1'b1;
          ST_K1: if (hits.keyConfirm) stepNext = ST_K2;
                 else begin stepNext = ST_IDLE; fwd = 1'b1; end
          ST_K2: if (hits.keyArm) begin
                   stepNext = ST_IDLE; armedNext = 1'b1; protectNext = 1'b1;
                 end else if (hits.keyEscape) stepNext = ST_K3;
                 else begin stepNext = ST_IDLE; fwd = 1'b1; end
          ST_K3: if (hits.keyOpen) stepNext = ST_K4;
                 else begin stepNext = ST_IDLE; fwd = 1'b1; end
          ST_K4: if (hits.keyConfirm) stepNext = ST_K5;
                 else begin stepNext = ST_IDLE; fwd = 1'b1; end
          ST_K5: if (hits.keyRelease) begin
                   stepNext = ST_IDLE; protectNext = 1'b0;
                 end else begin stepNext = ST_IDLE; fwd = 1'b1; end
          default: begin stepNext = ST_IDLE; fwd = 1'b1; end
        endcase
      end else begin
        fwd = 1'b1;
      end
      if (fwd) dataSeenNext = 1'b1;
    end else if (windowDone) begin
      stepNext     = ST_IDLE;
      armedNext    = 1'b0;
      dataSeenNext = 1'b0;
    end
    strobe.fwdEn    = fwd;
    strobe.cycleEnd = !loadValid && windowDone && dataSeen;
    strobe.permit   = !protectQ || armed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step     <= ST_IDLE;
      armed    <= 1'b0;
      protectQ <= 1'b0;
      dataSeen <= 1'b0;
    end else begin
      step     <= stepNext;
      armed    <= armedNext;
      protectQ <= protectNext;
      dataSeen <= dataSeenNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodOpen <= 1'b0;
      quietCnt   <= '0;
    end else if (loadValid) begin
      periodOpen <= 1'b1;
      quietCnt   <= '0;
    end else if (windowDone) begin
      periodOpen <= 1'b0;
      quietCnt   <= '0;
    end else if (periodOpen) begin
      quietCnt <= quietCnt + CNT_W'(1);
    end
  end

  assign protectOn = protectQ;

  // R4/R7: the mode moves only on a load cycle
  a_r7_mode_moves_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protectQ) |-> $past(loadValid));
  // R6: an armed period implies protection is on
  a_r6_armed_protected: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> protectQ);
  // R9: once data is seen the matcher sits idle
  a_r9_no_hunt_after_data: assert property (@(posedge clk) disable iff (!rstN)
    dataSeen |-> (step == ST_IDLE));
  // R3: the quiet counter never passes the window
  a_r3_counter_bound: assert property (@(posedge clk) disable iff (!rstN)
    periodOpen |-> (quietCnt < CNT_W'(WINDOW)));

endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData,
  output logic              writePermit,
  output logic              timerOnly,
  output logic              protectOn
);

  keyHit_t     hits;
  gateStrobe_t strobe;

  wp_gate_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .loadAddr(loadAddr), .loadData(loadData),
    .strobe(strobe), .hits(hits), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdData(fwdData), .writePermit(writePermit), .timerOnly(timerOnly)
  );

  wp_gate_control #(.WINDOW(WINDOW)) uCtrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .hits(hits),
    .strobe(strobe), .protectOn(protectOn)
  );

  // R5: a timer-only verdict comes only in protected mode
  a_r5_timer_needs_protect: assert property (@(posedge clk) disable iff (!rstN)
    timerOnly |-> protectOn);
  // R2: a forwarded byte follows a load strobe by one cycle
  a_r2_fwd_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> $past(loadValid));

endmodule

// File: tb/tb_wp_gate.sv
module tb_wp_gate;

  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [15:0] loadAddr = '0;
  logic [7:0]  loadData = '0;
  logic        fwdValid, writePermit, timerOnly, protectOn;
  logic [15:0] fwdAddr;
  logic [7:0]  fwdData;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wp_gate #(.ADDR_W(16), .DATA_W(8), .WINDOW(WIN)) dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAddr(loadAddr),
    .loadData(loadData), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdData(fwdData), .writePermit(writePermit), .timerOnly(timerOnly),
    .protectOn(protectOn)
  );

  // {address, data, expected forward}; one period, arms then loads data (R4, R9)
  localparam logic [24:0] VEC [6] = '{
    {16'h5555, 8'hAA, 1'b0},
    {16'h2AAA, 8'h55, 1'b0},
    {16'h5555, 8'hA0, 1'b0},
    {16'h0080, 8'h12, 1'b1},
    {16'h5555, 8'hAA, 1'b1},
    {16'h0081, 8'h34, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at next posedge, check at following negedge
  task automatic doLoad(input logic [15:0] a, input logic [7:0] d,
                        input bit expFwd, input string req);
    loadValid = 1'b1; loadAddr = a; loadData = d;
    @(posedge clk); @(negedge clk);
    loadValid = 1'b0;
    chk(fwdValid == expFwd, req, {31'd0, fwdValid}, {31'd0, expFwd});
    if (expFwd)
      chk({fwdAddr, fwdData} == {a, d}, req, {8'd0, fwdAddr, fwdData}, {8'd0, a, d});
  endtask

  task automatic waitEnd(input bit expPermit, input bit expTimer, input string req);
    bit early = 1'b0;
    for (int i = 1; i < WIN; i++) begin
      @(posedge clk); @(negedge clk);
      if (writePermit || timerOnly) early = 1'b1;
    end
    chk(!early, {req, " R3 early verdict"}, {31'd0, early}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk({writePermit, timerOnly} == {expPermit, expTimer}, req,
        {30'd0, writePermit, timerOnly}, {30'd0, expPermit, expTimer});
    @(posedge clk); @(negedge clk);
    chk(!writePermit && !timerOnly, {req, " R11 one cycle"},
        {30'd0, writePermit, timerOnly}, 32'd0);
  endtask

  task automatic unlockKey(input string req);
    doLoad(16'h5555, 8'hAA, 1'b0, req);
    doLoad(16'h2AAA, 8'h55, 1'b0, req);
    doLoad(16'h5555, 8'hA0, 1'b0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(!protectOn && !fwdValid && !writePermit && !timerOnly, "R1 reset",
        {28'd0, protectOn, fwdValid, writePermit, timerOnly}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table period: unlock from unprotected, then data (R4, R2, R9)
    for (int i = 0; i < 6; i++)
      doLoad(VEC[i][24:9], VEC[i][8:1], VEC[i][0], "R4/R2 table");
    chk(protectOn, "R4 protect set", {31'd0, protectOn}, 32'd1);
    waitEnd(1'b1, 1'b0, "R4 permit after unlock");

    // R5: protected, data without key
    doLoad(16'h0200, 8'h5A, 1'b1, "R5 data fwd");
    waitEnd(1'b0, 1'b1, "R5 timer only");

    // R6: protected, key then data; stays protected
    unlockKey("R6 key");
    doLoad(16'h0201, 8'h77, 1'b1, "R6 data");
    waitEnd(1'b1, 1'b0, "R6 permit");
    chk(protectOn, "R6 still protected", {31'd0, protectOn}, 32'd1);

    // R8: diverging second key byte becomes data; protected -> timer only
    doLoad(16'h5555, 8'hAA, 1'b0, "R8 first key byte held");
    doLoad(16'h2AAA, 8'h56, 1'b1, "R8 mismatch forwarded");
    waitEnd(1'b0, 1'b1, "R8 verdict");

    // R3: a load inside the window extends the period
    doLoad(16'h0300, 8'h01, 1'b1, "R3 first");
    for (int i = 1; i < WIN; i++) begin @(posedge clk); @(negedge clk); end
    chk(!writePermit && !timerOnly, "R3 no close before window", 
        {30'd0, writePermit, timerOnly}, 32'd0);
    doLoad(16'h0301, 8'h02, 1'b1, "R3 second");
    waitEnd(1'b0, 1'b1, "R3 extended close");

    // R10: key-only period yields no verdict
    unlockKey("R10 key");
    waitEnd(1'b0, 1'b0, "R10 no verdict");

    // R7: disable key then data
    doLoad(16'h5555, 8'hAA, 1'b0, "R7 key1");
    doLoad(16'h2AAA, 8'h55, 1'b0, "R7 key2");
    doLoad(16'h5555, 8'h80, 1'b0, "R7 key3");
    doLoad(16'h5555, 8'hAA, 1'b0, "R7 key4");
    doLoad(16'h2AAA, 8'h55, 1'b0, "R7 key5");
    chk(protectOn, "R7 still on before last", {31'd0, protectOn}, 32'd1);
    doLoad(16'h5555, 8'h20, 1'b0, "R7 key6");
    chk(!protectOn, "R7 protect cleared", {31'd0, protectOn}, 32'd0);
    doLoad(16'h0400, 8'hC3, 1'b1, "R7 data");
    waitEnd(1'b1, 1'b0, "R7 permit");

    // R9: key bytes after data are data and leave the mode alone
    doLoad(16'h0500, 8'h11, 1'b1, "R9 data");
    doLoad(16'h5555, 8'hAA, 1'b1, "R9 late key1");
    doLoad(16'h2AAA, 8'h55, 1'b1, "R9 late key2");
    doLoad(16'h5555, 8'hA0, 1'b1, "R9 late key3");
    chk(!protectOn, "R9 mode unchanged", {31'd0, protectOn}, 32'd0);
    waitEnd(1'b1, 1'b0, "R9 permit");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule